// File: doc/BRIEF.md
# BCD Clock with Field Adjust

This block keeps the time of day on a 24-hour dial. Hours, minutes and seconds are each held as a two-digit packed BCD byte. The block runs on the 50 MHz system clock. An internal divider makes a one-cycle enable once per second, and every state change happens on that enable. No divided clock is used anywhere.

Two mode inputs choose the behaviour:

- **Run mode:** the seconds count up and carry into minutes and then into hours.
- **Adjust mode:** a step key picks the hour, minute or second field in turn. Two hold inputs then move the picked field up or down by one per second. Each field wraps inside its own range and never carries into a neighbour.

While any field is picked, the free-running count is paused. This keeps a manual change from colliding with a carry.

Top module: `bcd_clock`

## Requirements
- R1: Each field is a packed BCD byte, with the tens digit in bits 7:4 and the units digit in bits 3:0. Hours stay within 00–23, and minutes and seconds stay within 00–59.
- R2: On each enable while the selection is idle, seconds advance by one. A 59→00 rollover of seconds carries into minutes, and a 59→00 rollover of minutes carries into hours. 23:59:59 becomes 00:00:00.
- R3: Time changes only on the enable. After reset is released, seconds first change on the TICK_DIV-th rising clock edge, and again every TICK_DIV edges after that. The default TICK_DIV is 50,000,000.
- R4: Adjust mode is active when mode_a=0 and mode_b=0. A press of step_n is a high-to-low change seen between two consecutive enables, and only counts in adjust mode. Each press moves adj_sel from idle to hour, hour to minute, minute to second, and second back to hour. Holding step_n low gives only one move. The adj_sel encoding is 00 idle, 01 hour, 10 minute, 11 second.
- R5: Outside adjust mode, adj_sel returns to 00 at the next clock edge and step_n presses are ignored.
- R6: In adjust mode, on each enable while a field is selected and inc_n=0, that field alone rises by one. Hours wrap 23→00, and minutes and seconds wrap 59→00.
- R7: In adjust mode, on each enable while a field is selected, inc_n=1 and dec_n=0, that field alone falls by one. Hours wrap 00→23, and minutes and seconds wrap 00→59. When inc_n and dec_n are both low, the field rises.
- R8: While adj_sel is not 00, the free-running count is paused. With inc_n and dec_n both high, all three fields hold.
- R9: A synchronous active-low reset clears all three fields to 00 and sets adj_sel to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_a | input | 1 | Mode input; both low selects adjust mode |
| mode_b | input | 1 | Mode input; both low selects adjust mode |
| step_n | input | 1 | Field-select key, active low, already debounced |
| inc_n | input | 1 | Hold low to raise the selected field |
| dec_n | input | 1 | Hold low to lower the selected field |
| hours_bcd | output | 8 | Hours, packed BCD |
| mins_bcd | output | 8 | Minutes, packed BCD |
| secs_bcd | output | 8 | Seconds, packed BCD |
| adj_sel | output | 2 | Current selection: 00 idle, 01 hour, 10 minute, 11 second |

## Verification
The assertions assume that step_n, inc_n and dec_n are already clean, synchronous levels, because debouncing is outside this block. They also assume the mode inputs change only on clock boundaries. The bench meets these assumptions by driving every input at the falling edge and keeping each level for whole cycles. The main instance is built with a divider of one, so every rising edge is an enable. A full simulated day and long adjust sweeps then fit in a short run. A second instance with a divider of five checks the enable spacing.

// File: rtl/clk_pkg.sv
package clk_pkg;

    localparam int NFIELD = 3;  // 0 seconds, 1 minutes, 2 hours

    typedef enum logic [1:0] {
        SEL_IDLE = 2'b00,
        SEL_HOUR = 2'b01,
        SEL_MIN  = 2'b10,
        SEL_SEC  = 2'b11
    } sel_e;

    // Upper bound of field i in packed BCD
    function automatic logic [7:0] field_limit(input int idx);
        return (idx == 2) ? 8'h23 : 8'h59;
    endfunction

    // One-hot field mask picked by the adjust selection
    function automatic logic [NFIELD-1:0] sel_mask(input sel_e s);
        case (s)
            SEL_HOUR: return 3'b100;
            SEL_MIN:  return 3'b010;
            SEL_SEC:  return 3'b001;
            default:  return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/clk_tick_gen.sv
module clk_tick_gen #(
    parameter int unsigned DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/clk_bcd_step.sv
module clk_bcd_step #(
    parameter logic [7:0] LIMIT = 8'h59
) (
    input  logic [7:0] val,
    input  logic       down,
    output logic [7:0] nxt,
    output logic       at_max
);
    always_comb begin
        at_max = (val == LIMIT);
        if (!down) begin
            if (at_max)                 nxt = 8'h00;
            else if (val[3:0] == 4'd9)  nxt = {val[7:4] + 4'd1, 4'd0};
            else                        nxt = {val[7:4], val[3:0] + 4'd1};
        end else begin
            if (val == 8'h00)           nxt = LIMIT;
            else if (val[3:0] == 4'd0)  nxt = {val[7:4] - 4'd1, 4'd9};
            else                        nxt = {val[7:4], val[3:0] - 4'd1};
        end
    end
endmodule

// File: rtl/clk_adj_fsm.sv
module clk_adj_fsm
    import clk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic adj_mode,
    input  logic step_n,
    output sel_e sel
);
    typedef struct packed {
        sel_e sel;
        logic key;   // step_n level seen at the last enable
    } fsm_t;

    fsm_t st_d, st_q;
    logic press;

    always_comb begin
        st_d  = st_q;
        press = tick && adj_mode && !step_n && st_q.key;
        if (tick) st_d.key = step_n;
        if (!adj_mode) begin
            st_d.sel = SEL_IDLE;
        end else if (press) begin
            case (st_q.sel)
                SEL_IDLE: st_d.sel = SEL_HOUR;
                SEL_HOUR: st_d.sel = SEL_MIN;
                SEL_MIN:  st_d.sel = SEL_SEC;
                default:  st_d.sel = SEL_HOUR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sel: SEL_IDLE, key: 1'b1};
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;
endmodule

// File: rtl/bcd_clock.sv
module bcd_clock
    import clk_pkg::*;
#(
    parameter int unsigned TICK_DIV = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_a,
    input  logic       mode_b,
    input  logic       step_n,
    input  logic       inc_n,
    input  logic       dec_n,
    output logic [7:0] hours_bcd,
    output logic [7:0] mins_bcd,
    output logic [7:0] secs_bcd,
    output logic [1:0] adj_sel
);
    typedef struct packed {
        logic [NFIELD-1:0][7:0] fld;
    } tm_t;

    tm_t tm_d, tm_q;
    logic tick;
    logic adj_mode;
    sel_e sel;
    logic [NFIELD-1:0][7:0] stepped;
    logic [NFIELD-1:0] at_max, f_inc, f_dec, hit;
    logic run, tune, carry;

    assign adj_mode = !mode_a && !mode_b;

    clk_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    clk_adj_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .adj_mode(adj_mode),
        .step_n  (step_n),
        .sel     (sel)
    );

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        clk_bcd_step #(.LIMIT(field_limit(i))) u_step (
            .val   (tm_q.fld[i]),
            .down  (f_dec[i]),
            .nxt   (stepped[i]),
            .at_max(at_max[i])
        );
    end

    always_comb begin
        run   = tick && (sel == SEL_IDLE);
        tune  = tick && adj_mode && (sel != SEL_IDLE);
        hit   = sel_mask(sel);
        carry = run;
        tm_d  = tm_q;
        for (int i = 0; i < NFIELD; i++) begin
            f_inc[i] = carry || (tune && hit[i] && !inc_n);
            f_dec[i] = tune && hit[i] && inc_n && !dec_n;
            carry    = carry && at_max[i];
            if (f_inc[i] || f_dec[i]) tm_d.fld[i] = stepped[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign secs_bcd  = tm_q.fld[0];
    assign mins_bcd  = tm_q.fld[1];
    assign hours_bcd = tm_q.fld[2];
    assign adj_sel   = sel;
endmodule

// File: rtl/bcd_clock_chk.sv
module bcd_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       mode_a,
    input logic       mode_b,
    input logic       inc_n,
    input logic       dec_n,
    input logic [7:0] hours_bcd,
    input logic [7:0] mins_bcd,
    input logic [7:0] secs_bcd,
    input logic [1:0] adj_sel
);
    logic adj;
    assign adj = !mode_a && !mode_b;

    AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hours_bcd <= 8'h23 && mins_bcd[7:4] <= 4'd5 && mins_bcd[3:0] <= 4'd9
        && secs_bcd[7:4] <= 4'd5 && secs_bcd[3:0] <= 4'd9 && hours_bcd[3:0] <= 4'd9); // R1

    AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && adj_sel == 2'b00 && hours_bcd == 8'h23 && mins_bcd == 8'h59 && secs_bcd == 8'h59)
        |=> (hours_bcd == 8'h00 && mins_bcd == 8'h00 && secs_bcd == 8'h00)); // R2

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(hours_bcd) && $stable(mins_bcd) && $stable(secs_bcd))); // R3

    AST_SEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && adj) |=> $stable(adj_sel)); // R4

    AST_SEL_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !adj |=> adj_sel == 2'b00); // R5

    AST_HOUR_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && adj && adj_sel == 2'b01 && !inc_n && hours_bcd == 8'h23) |=> hours_bcd == 8'h00); // R6

    AST_HOUR_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && adj && adj_sel == 2'b01 && inc_n && !dec_n && hours_bcd == 8'h00) |=> hours_bcd == 8'h23); // R7

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_sel != 2'b00 && inc_n && dec_n)
        |=> ($stable(hours_bcd) && $stable(mins_bcd) && $stable(secs_bcd))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (hours_bcd == 8'h00 && mins_bcd == 8'h00 && secs_bcd == 8'h00 && adj_sel == 2'b00)); // R9
endmodule

bind bcd_clock bcd_clock_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode_a   (mode_a),
    .mode_b   (mode_b),
    .inc_n    (inc_n),
    .dec_n    (dec_n),
    .hours_bcd(hours_bcd),
    .mins_bcd (mins_bcd),
    .secs_bcd (secs_bcd),
    .adj_sel  (adj_sel)
);

// File: tb/bcd_clock_tb.sv
module bcd_clock_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_a = 1'b1, mode_b = 1'b1;
    logic step_n = 1'b1, inc_n = 1'b1, dec_n = 1'b1;
    logic [7:0] hr, mn, sc, hr5, mn5, sc5;
    logic [1:0] sel, sel5;

    always #10 clk = ~clk;   // 50 MHz

    bcd_clock #(.TICK_DIV(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .step_n(step_n), .inc_n(inc_n), .dec_n(dec_n),
        .hours_bcd(hr), .mins_bcd(mn), .secs_bcd(sc), .adj_sel(sel));

    bcd_clock #(.TICK_DIV(5)) u_dut_div (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .step_n(step_n), .inc_n(inc_n), .dec_n(dec_n),
        .hours_bcd(hr5), .mins_bcd(mn5), .secs_bcd(sc5), .adj_sel(sel5));

    int nchk = 0, nfail = 0;
    int eh, em, es, esel, ekey;
    bit done = 0;

    function automatic logic [7:0] bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        cmp(tag, "hours", hr, bcd(eh));
        cmp(tag, "mins", mn, bcd(em));
        cmp(tag, "secs", sc, bcd(es));
        cmp(tag, "sel", {6'd0, sel}, 8'(esel));
    endtask

    // Drive one cycle at the falling edge, update the model, check at the next falling edge.
    task automatic apply(input string tag, input logic ma, input logic mb,
                         input logic stp, input logic up, input logic dn);
        int f;
        bit adj, press;
        mode_a = ma; mode_b = mb; step_n = stp; inc_n = up; dec_n = dn;
        adj   = !ma && !mb;
        press = adj && !stp && (ekey == 1);
        if (esel == 0) begin
            es++;
            if (es == 60) begin es = 0; em++; end
            if (em == 60) begin em = 0; eh++; end
            if (eh == 24) eh = 0;
        end else if (adj && (!up || !dn)) begin
            f = (esel == 1) ? eh : (esel == 2) ? em : es;
            if (!up) f = (f == ((esel == 1) ? 23 : 59)) ? 0 : f + 1;
            else     f = (f == 0) ? ((esel == 1) ? 23 : 59) : f - 1;
            if (esel == 1) eh = f; else if (esel == 2) em = f; else es = f;
        end
        if (!adj) esel = 0;
        else if (press) esel = (esel == 3) ? 1 : esel + 1;
        ekey = stp;
        @(negedge clk);
        chk_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mode_a = 1'b1; mode_b = 1'b1; step_n = 1'b1; inc_n = 1'b1; dec_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        eh = 0; em = 0; es = 0; esel = 0; ekey = 1;
        chk_all("R9");
        cmp("R9", "div secs", sc5, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R3: divided instance advances on every fifth edge after release
        for (int k = 1; k <= 12; k++) begin
            apply("R2", 1, 1, 1, 1, 1);
            cmp("R3", "div secs", sc5, bcd(k / 5));
        end
        // R1 R2: full-day sweep in run mode, including 23:59:59 wrap
        for (int k = 0; k < 86400; k++) apply("R1/R2", 1, 1, 1, 1, 1);
        // R9: reset from a nonzero time
        do_reset();
        apply("R2", 0, 0, 1, 1, 1);
        apply("R2", 0, 0, 1, 1, 1);
        // R4: press, hold (no second move), release
        apply("R4", 0, 0, 0, 1, 1);
        apply("R4", 0, 0, 0, 1, 1);
        apply("R4", 0, 0, 0, 1, 1);
        apply("R4", 0, 0, 1, 1, 1);
        // R8: selected, no step inputs: all fields hold
        for (int k = 0; k < 4; k++) apply("R8", 0, 0, 1, 1, 1);
        // hours: up, down, both low
        for (int k = 0; k < 30; k++) apply("R6", 0, 0, 1, 0, 1);
        for (int k = 0; k < 30; k++) apply("R7", 0, 0, 1, 1, 0);
        for (int k = 0; k < 5; k++)  apply("R7", 0, 0, 1, 0, 0);
        // minutes
        apply("R4", 0, 0, 0, 1, 1);
        apply("R4", 0, 0, 1, 1, 1);
        for (int k = 0; k < 70; k++) apply("R6", 0, 0, 1, 0, 1);
        for (int k = 0; k < 75; k++) apply("R7", 0, 0, 1, 1, 0);
        // seconds
        apply("R4", 0, 0, 0, 1, 1);
        apply("R4", 0, 0, 1, 1, 1);
        for (int k = 0; k < 70; k++) apply("R6", 0, 0, 1, 0, 1);
        for (int k = 0; k < 75; k++) apply("R7", 0, 0, 1, 1, 0);
        for (int k = 0; k < 3; k++)  apply("R8", 0, 0, 1, 1, 1);
        // second -> hour wrap of selection
        apply("R4", 0, 0, 0, 1, 1);
        apply("R4", 0, 0, 1, 1, 1);
        // R5: leave adjust mode, then presses in a mixed mode are ignored
        apply("R5", 1, 0, 1, 0, 1);
        apply("R5", 1, 0, 0, 0, 1);
        apply("R5", 1, 0, 1, 1, 1);
        apply("R5", 0, 1, 0, 1, 0);
        apply("R5", 0, 1, 1, 1, 1);
        for (int k = 0; k < 100; k++) apply("R2", 1, 1, 1, 1, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule